// File: doc/BRIEF.md
# SIMT Warp Scheduler with Reconvergence Stack

This block holds the control state of a small group of warps in the fetch stage of a SIMT core. Each warp has an active flag, a stalled flag, one program counter shared by all of its lanes, and a thread mask that marks which lanes execute. Every cycle the block picks one ready warp in rotating order. It presents that warp's id, PC and thread mask as the fetch request, then advances the warp's PC by one instruction step.

Decoded control commands arrive as one strobe with an opcode and operands, on behalf of the warp named in `cmd_wid`. They cover five cases:
- setting a warp's lane count;
- spawning further warps at an address;
- splitting a warp on a branch predicate;
- joining the two paths again;
- waiting at a counted barrier.

A split saves the not-taken lanes and the fall-through PC on a per-warp stack of parameterised depth, and a join restores them. A barrier stalls the warps that arrive at it until enough of them have arrived, and then releases them all in one cycle.

Top module: `simt_warp_sched`

## Requirements
- R1: After reset only warp 0 is active, with thread mask 0001 (lane 0 only) and PC equal to RESET_PC. No warp is stalled and every reconvergence stack is empty. The first fetch issues warp 0.
- R2: A warp is ready when it is active and not stalled. Each cycle the block issues the first ready warp found by counting upward, with wrap-around, starting from the warp after the one issued last. `fetch_valid` is low exactly when no warp is ready.
- R3: Issuing a warp adds PC_STEP (4) to that warp's PC, taking effect in the next cycle.
- R4: Opcode 0 (set lanes) with count n makes lanes 0..n-1 the thread mask of warp `cmd_wid` and clears its other lanes. It does not touch the warp's PC.
- R5: A warp whose thread mask becomes zero becomes inactive and is never issued. This happens through opcode 0 with count 0, or through a split with no taken lanes. A fetched mask is never zero.
- R6: Opcode 1 (spawn) with count n and address A activates every inactive warp whose id is below n. Each of these warps gets PC A, an all-ones thread mask and an empty stack. Warps that are already active are not changed.
- R7: Opcode 2 (split) with predicate P sets the mask of warp `cmd_wid` to P & mask. It pushes the pair (~P & mask, `cmd_addr`) onto that warp's stack.
- R8: Opcode 3 (join) pops the top entry of warp `cmd_wid`'s stack. If the saved mask is nonzero, it becomes the thread mask and the saved PC becomes the warp's PC. If the saved mask is zero, the mask and PC are left as they are.
- R9: A split onto a full stack, or a join on an empty stack, changes no state. It raises `stack_err` for exactly the following cycle. Valid pushes and pops leave `stack_err` low.
- R10: Opcode 4 (barrier) with id b and count n counts one arrival at barrier b. If the arrivals reach n, every warp waiting at b is unstalled in the same cycle, the counter for b is cleared, and the arriving warp is not stalled. Otherwise the arriving warp becomes stalled and is skipped by selection until the release.
- R11: Commands take effect at the next clock edge. If a command writes the PC of the warp issued in the same cycle, the command's PC wins over the step increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Control command strobe |
| cmd_op | input | 3 | Opcode: 0 set lanes, 1 spawn, 2 split, 3 join, 4 barrier |
| cmd_wid | input | WID_W | Warp that issued the command |
| cmd_count | input | CNT_W | Lane count, warp count or barrier count |
| cmd_addr | input | PC_W | Spawn address or split fall-through PC |
| cmd_pred | input | NUM_THREADS | Split taken predicate, one bit per lane |
| cmd_bar_id | input | BAR_W | Barrier id |
| fetch_valid | output | 1 | A warp is issued this cycle |
| fetch_wid | output | WID_W | Issued warp id |
| fetch_pc | output | PC_W | PC of the issued warp |
| fetch_tmask | output | NUM_THREADS | Thread mask of the issued warp |
| stack_err | output | 1 | Stack overflow or underflow in the previous cycle |

## Verification
The bench builds the block with 4 warps of 4 lanes, a stack depth of 2 and 2 barriers. The shallow stack means a third nested split already overflows, so both the overflow path and the underflow path occur often under random commands. With only two barrier ids, warps that stall at the same id pile up, and releases with several waiters become common. Barrier counts up to 4 with at most 4 warps reach both the release that happens on the first arrival and barriers that never release. Periodic resets clear those deadlocks.

// File: rtl/simt_warp_sched.sv
module simt_warp_sched #(
  parameter int NUM_WARPS   = 4,
  parameter int NUM_THREADS = 4,
  parameter int PC_W        = 32,
  parameter int STACK_DEPTH = 4,
  parameter int NUM_BARS    = 4,
  parameter int unsigned RESET_PC = 32'h100,
  parameter int PC_STEP     = 4,
  localparam int WID_W  = $clog2(NUM_WARPS),
  localparam int CNT_W  = $clog2((NUM_WARPS > NUM_THREADS ? NUM_WARPS : NUM_THREADS) + 1),
  localparam int BAR_W  = $clog2(NUM_BARS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [WID_W-1:0]       cmd_wid,
  input  logic [CNT_W-1:0]       cmd_count,
  input  logic [PC_W-1:0]        cmd_addr,
  input  logic [NUM_THREADS-1:0] cmd_pred,
  input  logic [BAR_W-1:0]       cmd_bar_id,
  output logic                   fetch_valid,
  output logic [WID_W-1:0]       fetch_wid,
  output logic [PC_W-1:0]        fetch_pc,
  output logic [NUM_THREADS-1:0] fetch_tmask,
  output logic                   stack_err
);
  localparam int SP_W   = $clog2(STACK_DEPTH + 1);
  localparam int STK_W  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int WCNT_W = $clog2(NUM_WARPS + 1);

  logic [NUM_WARPS-1:0]   active, stalled, ready;
  logic [PC_W-1:0]        pc    [NUM_WARPS];
  logic [NUM_THREADS-1:0] tmask [NUM_WARPS];
  logic [SP_W-1:0]        sp    [NUM_WARPS];
  logic [NUM_THREADS-1:0] stk_m  [NUM_WARPS][STACK_DEPTH];
  logic [PC_W-1:0]        stk_pc [NUM_WARPS][STACK_DEPTH];
  logic [WCNT_W-1:0]      bar_cnt  [NUM_BARS];
  logic [NUM_WARPS-1:0]   bar_wait [NUM_BARS];
  logic [WID_W-1:0]       last, sel;

  function automatic logic [NUM_THREADS-1:0] low_lanes(input logic [CNT_W-1:0] n);
    for (int l = 0; l < NUM_THREADS; l++) low_lanes[l] = (l < int'(n));
  endfunction

  assign ready = active & ~stalled;

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = last;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      if (!found && ready[(int'(last) + k) % NUM_WARPS]) begin
        sel   = WID_W'((int'(last) + k) % NUM_WARPS);
        found = 1'b1;
      end
    end
  end

  assign fetch_valid = |ready;
  assign fetch_wid   = sel;
  assign fetch_pc    = pc[sel];
  assign fetch_tmask = tmask[sel];

  wire is_tmc   = cmd_valid && cmd_op == 3'd0;
  wire is_spawn = cmd_valid && cmd_op == 3'd1;
  wire is_split = cmd_valid && cmd_op == 3'd2;
  wire is_join  = cmd_valid && cmd_op == 3'd3;
  wire is_bar   = cmd_valid && cmd_op == 3'd4;

  wire [SP_W-1:0]        cur_sp    = sp[cmd_wid];
  wire [NUM_THREADS-1:0] cur_tmask = tmask[cmd_wid];
  wire [NUM_THREADS-1:0] taken     = cmd_pred & cur_tmask;
  wire [NUM_THREADS-1:0] not_taken = ~cmd_pred & cur_tmask;
  wire                   stk_full  = int'(cur_sp) >= STACK_DEPTH;
  wire                   stk_empty = cur_sp == '0;
  wire [STK_W-1:0]       push_idx  = stk_full ? '0 : STK_W'(cur_sp);
  wire [STK_W-1:0]       pop_idx   = stk_empty ? '0 : STK_W'(int'(cur_sp) - 1);
  wire [NUM_THREADS-1:0] pop_m     = stk_m[cmd_wid][pop_idx];
  wire [PC_W-1:0]        pop_pc    = stk_pc[cmd_wid][pop_idx];
  wire [NUM_THREADS-1:0] tmc_m     = low_lanes(cmd_count);
  wire                   bar_rel   = (int'(bar_cnt[cmd_bar_id]) + 1) >= int'(cmd_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= NUM_WARPS'(1);
      stalled   <= '0;
      last      <= WID_W'(NUM_WARPS - 1);
      stack_err <= 1'b0;
      for (int w = 0; w < NUM_WARPS; w++) begin
        pc[w]    <= PC_W'(RESET_PC);
        tmask[w] <= (w == 0) ? NUM_THREADS'(1) : '0;
        sp[w]    <= '0;
      end
      for (int b = 0; b < NUM_BARS; b++) begin
        bar_cnt[b]  <= '0;
        bar_wait[b] <= '0;
      end
    end else begin
      stack_err <= 1'b0;
      if (fetch_valid) begin
        pc[sel] <= pc[sel] + PC_W'(PC_STEP);
        last    <= sel;
      end
      if (is_tmc) begin
        tmask[cmd_wid] <= tmc_m;
        if (tmc_m == '0) active[cmd_wid] <= 1'b0;
      end
      if (is_spawn) begin
        for (int w = 0; w < NUM_WARPS; w++) begin
          if (w < int'(cmd_count) && !active[w]) begin
            active[w]  <= 1'b1;
            stalled[w] <= 1'b0;
            pc[w]      <= cmd_addr;
            tmask[w]   <= '1;
            sp[w]      <= '0;
          end
        end
      end
      if (is_split) begin
        if (stk_full) begin
          stack_err <= 1'b1;
        end else begin
          stk_m[cmd_wid][push_idx]  <= not_taken;
          stk_pc[cmd_wid][push_idx] <= cmd_addr;
          sp[cmd_wid]               <= cur_sp + 1'b1;
          tmask[cmd_wid]            <= taken;
          if (taken == '0) active[cmd_wid] <= 1'b0;
        end
      end
      if (is_join) begin
        if (stk_empty) begin
          stack_err <= 1'b1;
        end else begin
          sp[cmd_wid] <= cur_sp - 1'b1;
          if (pop_m != '0) begin
            tmask[cmd_wid] <= pop_m;
            pc[cmd_wid]    <= pop_pc;
          end
        end
      end
      if (is_bar) begin
        if (bar_rel) begin
          bar_cnt[cmd_bar_id]  <= '0;
          bar_wait[cmd_bar_id] <= '0;
          for (int w = 0; w < NUM_WARPS; w++)
            if (bar_wait[cmd_bar_id][w]) stalled[w] <= 1'b0;
        end else begin
          bar_cnt[cmd_bar_id]           <= bar_cnt[cmd_bar_id] + 1'b1;
          bar_wait[cmd_bar_id][cmd_wid] <= 1'b1;
          stalled[cmd_wid]              <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/simt_warp_sched_chk.sv
module simt_warp_sched_chk #(
  parameter int NUM_WARPS   = 4,
  parameter int NUM_THREADS = 4,
  parameter int STACK_DEPTH = 4,
  parameter int WID_W = 2,
  parameter int CNT_W = 3,
  parameter int SP_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_op,
  input logic [WID_W-1:0]       cmd_wid,
  input logic [CNT_W-1:0]       cmd_count,
  input logic                   fetch_valid,
  input logic [WID_W-1:0]       fetch_wid,
  input logic [NUM_THREADS-1:0] fetch_tmask,
  input logic                   stack_err,
  input logic [NUM_WARPS-1:0]   active,
  input logic [NUM_WARPS-1:0]   stalled,
  input logic [SP_W-1:0]        cur_sp
);
  // R9
  split_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && int'(cur_sp) == STACK_DEPTH) |=> stack_err);
  // R9
  join_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && cur_sp == '0) |=> stack_err);
  // R9
  push_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && int'(cur_sp) < STACK_DEPTH) |=> !stack_err);
  // R5
  tmc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && cmd_count == '0) |=> !active[$past(cmd_wid)]);
  // R5
  mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_tmask != '0);
  // R10
  no_stalled_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (active[fetch_wid] && !stalled[fetch_wid]));
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> (active & ~stalled) == '0);
endmodule

bind simt_warp_sched simt_warp_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .NUM_THREADS(NUM_THREADS), .STACK_DEPTH(STACK_DEPTH),
  .WID_W(WID_W), .CNT_W(CNT_W), .SP_W(SP_W)
) u_chk (.*);

// File: tb/simt_warp_sched_tb.sv
module simt_warp_sched_tb;
  localparam int NW = 4, NT = 4, PW = 32, SD = 2, NB = 2;
  localparam int WW = 2, CW = 3, BW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [WW-1:0] cmd_wid = '0;
  logic [CW-1:0] cmd_count = '0;
  logic [PW-1:0] cmd_addr = '0;
  logic [NT-1:0] cmd_pred = '0;
  logic [BW-1:0] cmd_bar_id = '0;
  logic fetch_valid, stack_err;
  logic [WW-1:0] fetch_wid;
  logic [PW-1:0] fetch_pc;
  logic [NT-1:0] fetch_tmask;

  always #2 clk = ~clk;

  simt_warp_sched #(.NUM_WARPS(NW), .NUM_THREADS(NT), .PC_W(PW),
    .STACK_DEPTH(SD), .NUM_BARS(NB)) u_dut (.*);

  int nchk = 0, nfail = 0;
  bit m_act [NW], m_stl [NW];
  logic [PW-1:0] m_pc [NW];
  logic [NT-1:0] m_tm [NW];
  int m_sp [NW];
  logic [NT-1:0] s_m [NW][SD];
  logic [PW-1:0] s_pc [NW][SD];
  int m_bc [NB];
  bit m_bw [NB][NW];
  int m_last;
  bit m_err;

  function automatic int pick();
    for (int k = 1; k <= NW; k++) begin
      int i = (m_last + k) % NW;
      if (m_act[i] && !m_stl[i]) return i;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin
      m_act[w] = (w == 0); m_stl[w] = 0; m_pc[w] = 32'h100;
      m_tm[w] = (w == 0) ? 4'b0001 : 4'b0000; m_sp[w] = 0;
    end
    for (int b = 0; b < NB; b++) begin
      m_bc[b] = 0;
      for (int w = 0; w < NW; w++) m_bw[b][w] = 0;
    end
    m_last = NW - 1; m_err = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    int s = pick();
    chk(fetch_valid == (s >= 0), req, "fetch_valid", 64'(fetch_valid), 64'(s >= 0));
    chk(stack_err == m_err, req, "stack_err", 64'(stack_err), 64'(m_err));
    if (s >= 0) begin
      chk(int'(fetch_wid) == s, req, "fetch_wid", 64'(fetch_wid), 64'(s));
      chk(fetch_pc == m_pc[s], req, "fetch_pc", 64'(fetch_pc), 64'(m_pc[s]));
      chk(fetch_tmask == m_tm[s], req, "fetch_tmask", 64'(fetch_tmask), 64'(m_tm[s]));
    end
  endtask

  task automatic model_step(input bit v, input int op, input int w, input int n,
                            input logic [PW-1:0] a, input logic [NT-1:0] p, input int b);
    int s = pick();
    if (s >= 0) begin m_pc[s] = m_pc[s] + 4; m_last = s; end
    m_err = 0;
    if (v) case (op)
      0: begin
        logic [NT-1:0] mk = '0;
        for (int l = 0; l < NT; l++) mk[l] = (l < n);
        m_tm[w] = mk;
        if (mk == 0) m_act[w] = 0;
      end
      1: for (int i = 0; i < NW; i++)
           if (i < n && !m_act[i]) begin
             m_act[i] = 1; m_stl[i] = 0; m_pc[i] = a; m_tm[i] = '1; m_sp[i] = 0;
           end
      2: if (m_sp[w] == SD) m_err = 1;
         else begin
           s_m[w][m_sp[w]] = ~p & m_tm[w]; s_pc[w][m_sp[w]] = a; m_sp[w]++;
           m_tm[w] = p & m_tm[w];
           if (m_tm[w] == 0) m_act[w] = 0;
         end
      3: if (m_sp[w] == 0) m_err = 1;
         else begin
           m_sp[w]--;
           if (s_m[w][m_sp[w]] != 0) begin
             m_tm[w] = s_m[w][m_sp[w]]; m_pc[w] = s_pc[w][m_sp[w]];
           end
         end
      4: if (m_bc[b] + 1 >= n) begin
           for (int i = 0; i < NW; i++) begin
             if (m_bw[b][i]) m_stl[i] = 0;
             m_bw[b][i] = 0;
           end
           m_bc[b] = 0;
         end else begin
           m_bc[b]++; m_bw[b][w] = 1; m_stl[w] = 1;
         end
      default: ;
    endcase
  endtask

  task automatic cyc(input bit v, input int op, input int w, input int n,
                     input logic [PW-1:0] a, input logic [NT-1:0] p, input int b,
                     input string req);
    check_out(req);
    cmd_valid = v; cmd_op = 3'(op); cmd_wid = WW'(w); cmd_count = CW'(n);
    cmd_addr = a; cmd_pred = p; cmd_bar_id = BW'(b);
    model_step(v, op, w, n, a, p, b);
    @(negedge clk);
  endtask

  task automatic idle(input int k, input string req);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, '0, '0, 0, req);
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_valid = 0;
    @(negedge clk); @(negedge clk);
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    idle(2, "R1");
    cyc(1, 0, 0, 3, '0, '0, 0, "R4");
    idle(2, "R4");
    cyc(1, 1, 0, 4, 32'h2000, '0, 0, "R6");
    idle(6, "R2");
    cyc(1, 1, 0, 4, 32'h5000, '0, 0, "R6");
    idle(2, "R3");
    cyc(1, 2, 1, 0, 32'h3000, 4'b0101, 0, "R7");
    cyc(1, 2, 1, 0, 32'h3100, 4'b0001, 0, "R7");
    cyc(1, 2, 1, 0, 32'h3200, 4'b0001, 0, "R9");
    idle(2, "R9");
    cyc(1, 3, 1, 0, '0, '0, 0, "R8");
    cyc(1, 3, 1, 0, '0, '0, 0, "R11");
    cyc(1, 3, 1, 0, '0, '0, 0, "R9");
    idle(2, "R9");
    cyc(1, 2, 2, 0, 32'h4000, 4'b1111, 0, "R7");
    cyc(1, 3, 2, 0, '0, '0, 0, "R8");
    idle(2, "R8");
    cyc(1, 4, 0, 3, '0, '0, 0, "R10");
    idle(2, "R10");
    cyc(1, 4, 1, 3, '0, '0, 0, "R10");
    idle(3, "R10");
    cyc(1, 4, 2, 3, '0, '0, 0, "R10");
    idle(4, "R10");
    cyc(1, 4, 3, 1, '0, '0, 1, "R10");
    cyc(1, 0, 3, 0, '0, '0, 0, "R5");
    idle(4, "R5");
    cyc(1, 2, 2, 0, 32'h4400, 4'b0000, 0, "R5");
    idle(3, "R5");

    for (int r = 0; r < 20; r++) begin
      do_reset();
      for (int c = 0; c < 400; c++) begin
        int cand [$];
        int op, w, n, sel;
        string req;
        for (int i = 0; i < NW; i++) if (m_act[i] && !m_stl[i]) cand.push_back(i);
        sel = $urandom_range(0, 99);
        op = (sel < 10) ? 0 : (sel < 22) ? 1 : (sel < 45) ? 2 : (sel < 68) ? 3 : 4;
        w = cand.size() > 0 ? cand[$urandom_range(0, cand.size() - 1)] : 0;
        n = (op == 0 && $urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 4);
        req = op == 0 ? "R4" : op == 1 ? "R6" : op == 2 ? "R7" : op == 3 ? "R8" : "R10";
        if ($urandom_range(0, 3) == 0 || (cand.size() == 0 && op != 1))
          cyc(0, 0, 0, 0, '0, '0, 0, "R2");
        else
          cyc(1, op, w, n, {$urandom_range(0, 32'h3fff), 2'b00},
              NT'($urandom_range(0, 15)), $urandom_range(0, NB - 1), req);
      end
    end
    check_out("R11");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule